// File: doc/BRIEF.md
# Privilege-Checked Interrupt Pending Register

This block is a read-only 32-bit status word that reports three pending conditions: an asynchronous error, a normal interrupt (IRQ) and a fast interrupt (FIQ). Each condition has a physical source and a virtual source. A per-condition select input decides which of the two is reported. The asynchronous error can also be set to edge-triggered mode. In that mode a rising edge of the physical input is held in a latch, and the latch stays set until the physical error is taken.

Software reads the word through a coprocessor-style system register access that carries five encoding fields. The block answers only its own encoding. It then checks the requester's privilege level and a hypervisor trap-control bit. Depending on the result, it does one of four things:
- returns the status word,
- signals an undefined-instruction fault,
- traps to a hypervisor running in 64-bit mode,
- traps to a hypervisor running in 32-bit mode.

Both trap kinds carry syndrome code 0x03. The outcome appears on registered outputs one cycle after the request.

Top module: `pend_stat_reg`

## Requirements
- R1: In the returned word, bit 8 is the async-error pending bit, bit 7 is the IRQ pending bit and bit 6 is the FIQ pending bit. Every other bit is zero, and `rd_data_o` is all zero whenever `rd_valid_o` is low.
- R2: A request is handled only when cp=4'b1111, op1=3'b000, crn=4'b1100, crm=4'b0001 and op2=3'b000. For any other encoding, or with no request, no outcome output is raised.
- R3: A matching request from privilege level 0 raises `undef_o` and returns no data.
- R4: At privilege level 1, when `hyp_en_i` and `trap_crn12_i` are both high and `hyp_aa32_i` is low, `trap_sys_o` is raised with `syndrome_o` = 8'h03.
- R5: At privilege level 1, when `hyp_en_i`, `trap_crn12_i` and `hyp_aa32_i` are all high, `trap_hyp_o` is raised with `syndrome_o` = 8'h03. `syndrome_o` is zero whenever no trap is raised.
- R6: The status word is returned with `rd_valid_o` in two cases. The first is privilege level 1 when either `hyp_en_i` or `trap_crn12_i` is low. The second is privilege levels 2 and 3, whatever the trap inputs are.
- R7: Each reported bit takes its virtual input when its select input is high, and its physical input otherwise.
- R8: The IRQ bit, the FIQ bit, and the async-error bit in level mode (`serr_edge_i` low) follow the physical input as sampled in the request cycle.
- R9: In edge mode, a rising edge of `phys_serr_i` sets a latch. The latch stays set after the input falls. One cycle with `serr_taken_i` high clears it. A level that is held high does not set the latch again.
- R10: If a rising edge and `serr_taken_i` fall in the same cycle, the latch ends up set.
- R11: `rd_valid_o`, `undef_o`, `trap_sys_o` and `trap_hyp_o` are mutually exclusive. They are registered one cycle after the request, and all are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phys_serr_i | input | 1 | Physical async-error pending |
| virt_serr_i | input | 1 | Virtual async-error pending |
| serr_vsel_i | input | 1 | Report virtual async error |
| serr_edge_i | input | 1 | Async error is edge-triggered |
| serr_taken_i | input | 1 | Physical async error is being taken |
| phys_irq_i | input | 1 | Physical IRQ pending |
| virt_irq_i | input | 1 | Virtual IRQ pending |
| irq_vsel_i | input | 1 | Report virtual IRQ |
| phys_fiq_i | input | 1 | Physical FIQ pending |
| virt_fiq_i | input | 1 | Virtual FIQ pending |
| fiq_vsel_i | input | 1 | Report virtual FIQ |
| req_i | input | 1 | Access request strobe |
| cp_i | input | 4 | Coprocessor number field |
| op1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| op2_i | input | 3 | Second opcode field |
| priv_i | input | 2 | Current privilege level |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_aa32_i | input | 1 | Hypervisor runs in 32-bit mode |
| trap_crn12_i | input | 1 | Hypervisor trap control for crn=12 |
| rd_valid_o | output | 1 | Read data returned |
| rd_data_o | output | 32 | Status word |
| undef_o | output | 1 | Undefined-instruction fault |
| trap_sys_o | output | 1 | System-access trap to 64-bit hypervisor |
| trap_hyp_o | output | 1 | Hypervisor trap to 32-bit hypervisor |
| syndrome_o | output | 8 | Trap syndrome code |

## Verification
The outcome checks compare each outcome with the privilege level of the cycle before it. They assume `priv_i` and `req_i` are quiet and stable while reset is asserted, and the stimulus keeps them so: both stay at zero until a clock after reset is released. The latch checks assume `serr_edge_i` changes only between accesses. The stimulus changes it only at falling clock edges, with no request pending at that time.

// File: rtl/pend_stat_pkg.sv
package pend_stat_pkg;
  localparam int DATA_W   = 32;
  localparam int SYN_W    = 8;
  localparam int N_SRC    = 3;
  // source index doubles as the order of the bits in the word
  localparam int FIQ_IDX  = 0;
  localparam int IRQ_IDX  = 1;
  localparam int SERR_IDX = 2;
  localparam int BASE_BIT = 6;
  localparam logic [SYN_W-1:0] SYN_TRAP = 8'h03;
  localparam logic [3:0] ENC_CP  = 4'b1111;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b1100;
  localparam logic [3:0] ENC_CRM = 4'b0001;
  localparam logic [2:0] ENC_OP2 = 3'b000;
  localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(((1 << N_SRC) - 1) << BASE_BIT);

  typedef struct packed {
    logic rd;
    logic undef;
    logic trap_sys;
    logic trap_hyp;
  } outcome_t;
endpackage

// File: rtl/pend_src_sel.sv
module pend_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phys_i,
  input  logic virt_i,
  input  logic vsel_i,
  input  logic edge_i,
  input  logic taken_i,
  output logic pend_o
);
  logic prev_q, flag_q, rise;

  assign rise = phys_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= phys_i;
      flag_q <= rise | (flag_q & ~taken_i);  // new edge beats take
    end
  end

  assign pend_o = vsel_i ? virt_i : (edge_i ? flag_q : phys_i);

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && taken_i) |=> flag_q);
  // R9
  take_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phys_i && taken_i) |=> !flag_q);
endmodule

// File: rtl/pend_access_dec.sv
module pend_access_dec
  import pend_stat_pkg::*;
(
  input  logic       req_i,
  input  logic [3:0] cp_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic [1:0] priv_i,
  input  logic       hyp_en_i,
  input  logic       hyp_aa32_i,
  input  logic       trap_crn12_i,
  output outcome_t   out_o
);
  logic hit, trap;

  assign hit = req_i && cp_i == ENC_CP && op1_i == ENC_OP1 && crn_i == ENC_CRN
               && crm_i == ENC_CRM && op2_i == ENC_OP2;
  assign trap = (priv_i == 2'd1) && hyp_en_i && trap_crn12_i;

  always_comb begin
    out_o = '0;
    if (hit) begin
      if (priv_i == 2'd0)  out_o.undef    = 1'b1;
      else if (!trap)      out_o.rd       = 1'b1;
      else if (hyp_aa32_i) out_o.trap_hyp = 1'b1;
      else                 out_o.trap_sys = 1'b1;
    end
  end
endmodule

// File: rtl/pend_stat_reg.sv
module pend_stat_reg
  import pend_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phys_serr_i,
  input  logic              virt_serr_i,
  input  logic              serr_vsel_i,
  input  logic              serr_edge_i,
  input  logic              serr_taken_i,
  input  logic              phys_irq_i,
  input  logic              virt_irq_i,
  input  logic              irq_vsel_i,
  input  logic              phys_fiq_i,
  input  logic              virt_fiq_i,
  input  logic              fiq_vsel_i,
  input  logic              req_i,
  input  logic [3:0]        cp_i,
  input  logic [2:0]        op1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        op2_i,
  input  logic [1:0]        priv_i,
  input  logic              hyp_en_i,
  input  logic              hyp_aa32_i,
  input  logic              trap_crn12_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              undef_o,
  output logic              trap_sys_o,
  output logic              trap_hyp_o,
  output logic [SYN_W-1:0]  syndrome_o
);
  logic [N_SRC-1:0] phys, virt, vsel, edge_en, taken, pend;
  outcome_t         nxt, out_q;
  logic [DATA_W-1:0] data_q;

  assign phys    = {phys_serr_i, phys_irq_i, phys_fiq_i};
  assign virt    = {virt_serr_i, virt_irq_i, virt_fiq_i};
  assign vsel    = {serr_vsel_i, irq_vsel_i, fiq_vsel_i};
  assign edge_en = {serr_edge_i, 1'b0, 1'b0};
  assign taken   = {serr_taken_i, 1'b0, 1'b0};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    pend_src_sel u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phys_i (phys[g]),
      .virt_i (virt[g]),
      .vsel_i (vsel[g]),
      .edge_i (edge_en[g]),
      .taken_i(taken[g]),
      .pend_o (pend[g])
    );
  end

  pend_access_dec u_dec (
    .req_i       (req_i),
    .cp_i        (cp_i),
    .op1_i       (op1_i),
    .crn_i       (crn_i),
    .crm_i       (crm_i),
    .op2_i       (op2_i),
    .priv_i      (priv_i),
    .hyp_en_i    (hyp_en_i),
    .hyp_aa32_i  (hyp_aa32_i),
    .trap_crn12_i(trap_crn12_i),
    .out_o       (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      data_q <= '0;
    end else begin
      out_q  <= nxt;
      data_q <= nxt.rd ? DATA_W'(pend) << BASE_BIT : '0;
    end
  end

  assign rd_valid_o = out_q.rd;
  assign undef_o    = out_q.undef;
  assign trap_sys_o = out_q.trap_sys;
  assign trap_hyp_o = out_q.trap_hyp;
  assign rd_data_o  = data_q;
  assign syndrome_o = (out_q.trap_sys | out_q.trap_hyp) ? SYN_TRAP : '0;

  // R11
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_o, undef_o, trap_sys_o, trap_hyp_o}));
  // R3
  undef_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> ($past(priv_i) == 2'd0 && rd_data_o == '0));
  // R4
  trap_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_sys_o || trap_hyp_o) |-> ($past(priv_i) == 2'd1 && syndrome_o == SYN_TRAP));
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o & ~LIVE_MASK) == '0) && (rd_valid_o || rd_data_o == '0));
  // R2
  no_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(rd_valid_o || undef_o || trap_sys_o || trap_hyp_o));
endmodule

// File: tb/pend_stat_reg_test.sv
module pend_stat_reg_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic phys_serr = 0, virt_serr = 0, serr_vsel = 0, serr_edge = 0, serr_taken = 0;
  logic phys_irq = 0, virt_irq = 0, irq_vsel = 0;
  logic phys_fiq = 0, virt_fiq = 0, fiq_vsel = 0;
  logic req = 0;
  logic [3:0] cp = 4'b1111, crn = 4'b1100, crm = 4'b0001;
  logic [2:0] op1 = 3'b000, op2 = 3'b000;
  logic [1:0] priv = 2'd0;
  logic hyp_en = 0, hyp_aa32 = 0, trap12 = 0;
  logic rd_valid, undef, trap_sys, trap_hyp;
  logic [31:0] rd_data;
  logic [7:0] syn;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pend_stat_reg uut (
    .clk_i(clk), .rst_ni(rst_n),
    .phys_serr_i(phys_serr), .virt_serr_i(virt_serr), .serr_vsel_i(serr_vsel),
    .serr_edge_i(serr_edge), .serr_taken_i(serr_taken),
    .phys_irq_i(phys_irq), .virt_irq_i(virt_irq), .irq_vsel_i(irq_vsel),
    .phys_fiq_i(phys_fiq), .virt_fiq_i(virt_fiq), .fiq_vsel_i(fiq_vsel),
    .req_i(req), .cp_i(cp), .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2),
    .priv_i(priv), .hyp_en_i(hyp_en), .hyp_aa32_i(hyp_aa32), .trap_crn12_i(trap12),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .undef_o(undef),
    .trap_sys_o(trap_sys), .trap_hyp_o(trap_hyp), .syndrome_o(syn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // outcome vector {rd, undef, sys, hyp}
  function automatic logic [3:0] outs();
    return {rd_valid, undef, trap_sys, trap_hyp};
  endfunction

  function automatic logic [31:0] word(input logic a, input logic i, input logic f);
    return {23'b0, a, i, f, 6'b0};
  endfunction

  // issue one access at a falling edge, sample at the next falling edge
  task automatic access(input logic [1:0] pl);
    priv = pl;
    req  = 1'b1;
    @(negedge clk);
    req  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset outcomes", outs(), 4'b0000);
    chk("R11 reset data", rd_data, 0);
  endtask

  task automatic t_priv();
    access(2'd0);
    chk("R3 undef", outs(), 4'b0100);
    chk("R3 no data", rd_data, 0);
    hyp_en = 1; trap12 = 1; hyp_aa32 = 0; phys_irq = 1;
    access(2'd1);
    chk("R4 sys trap", outs(), 4'b0010);
    chk("R4 syndrome", syn, 8'h03);
    hyp_aa32 = 1;
    access(2'd1);
    chk("R5 hyp trap", outs(), 4'b0001);
    chk("R5 syndrome", syn, 8'h03);
    access(2'd2);
    chk("R6 pl2 read", outs(), 4'b1000);
    chk("R6 pl2 data", rd_data, word(0, 1, 0));
    chk("R5 no syndrome on read", syn, 0);
    access(2'd3);
    chk("R6 pl3 read", outs(), 4'b1000);
    trap12 = 0;
    access(2'd1);
    chk("R6 pl1 trap bit clear", outs(), 4'b1000);
    trap12 = 1; hyp_en = 0;
    access(2'd1);
    chk("R6 pl1 hyp disabled", outs(), 4'b1000);
    hyp_en = 0; trap12 = 0; hyp_aa32 = 0; phys_irq = 0;
  endtask

  task automatic t_decode();
    crm = 4'b0010;
    access(2'd2);
    chk("R2 bad crm", outs(), 4'b0000);
    crm = 4'b0001; cp = 4'b1110;
    access(2'd0);
    chk("R2 bad cp", outs(), 4'b0000);
    cp = 4'b1111; op2 = 3'b001;
    access(2'd2);
    chk("R2 bad op2", outs(), 4'b0000);
    op2 = 3'b000;
    idle(1);
    chk("R2 no request", outs(), 4'b0000);
  endtask

  task automatic t_select();
    phys_irq = 1; phys_fiq = 1; phys_serr = 1;
    access(2'd2);
    chk("R8 level all set", rd_data, word(1, 1, 1));
    irq_vsel = 1; fiq_vsel = 1; serr_vsel = 1;
    access(2'd2);
    chk("R7 virtual clear", rd_data, word(0, 0, 0));
    virt_fiq = 1; phys_irq = 0;
    access(2'd2);
    chk("R7 virtual fiq only", rd_data, word(0, 0, 1));
    irq_vsel = 0; fiq_vsel = 0; serr_vsel = 0; virt_fiq = 0;
    phys_fiq = 0;
    access(2'd2);
    chk("R8 level serr only", rd_data, word(1, 0, 0));
    phys_serr = 0;
    access(2'd2);
    chk("R8 level follows low", rd_data, word(0, 0, 0));
  endtask

  task automatic t_edge();
    serr_edge = 1;
    idle(1);
    phys_serr = 1;
    idle(1);
    phys_serr = 0;
    idle(1);
    access(2'd3);
    chk("R9 latch held", rd_data, word(1, 0, 0));
    serr_taken = 1;
    idle(1);
    serr_taken = 0;
    access(2'd3);
    chk("R9 take clears", rd_data, word(0, 0, 0));
    phys_serr = 1; serr_taken = 1;
    idle(1);
    serr_taken = 0;
    access(2'd3);
    chk("R10 set wins", rd_data, word(1, 0, 0));
    serr_taken = 1;
    idle(1);
    serr_taken = 0;
    idle(1);
    access(2'd3);
    chk("R9 held level no reset", rd_data, word(0, 0, 0));
    phys_serr = 0; serr_edge = 0;
    idle(1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_priv();
    t_decode();
    t_select();
    t_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule